// File: doc/BRIEF.md
# Descriptor-Chained DMA Command Sequencer

This block drives a single DMA channel from a linked chain of 16-byte descriptors in memory. The descriptor at the command pointer is read as four 32-bit words. Its opcode and key are decoded. The block then hands a transfer to a device-side engine, executes a no-op, or halts. When a descriptor finishes, the channel status and residual byte count are stored back into the last word of that descriptor.

Each descriptor carries three 2-bit condition modes: interrupt, branch and wait. Each mode is judged against a masked compare of the four device-status inputs. Three select words supply the mask and the compare value for these comparisons. A true wait condition makes the channel fetch and execute the same descriptor again without writing anything back. A taken branch jumps to the address in the descriptor's third word, and otherwise the pointer steps forward by 16 bytes. A system-side controller drives the run level, the wake and flush pulses and the pointer load. Word load and store commands belong to another unit; this sequencer stops the channel when it decodes one.

Top module: `dcs_seq`

## Requirements
- R1: After reset the status word, the command pointer, the interrupt output and both request outputs are zero.
- R2: A descriptor is fetched as four 32-bit reads at pointer+0, +4, +8 and +12, in that order. Word 0 holds the request length in bits 15:0 and the command halfword in bits 31:16. Word 1 holds the data address. Word 2 holds the dependent word. Word 3 holds the residual count in bits 15:0 and the transfer status in bits 31:16.
- R3: A fetch starts only while the run input and the ACTIVE bit are both high and the previous descriptor has finished. Starting a fetch clears the WAKE bit.
- R4: Opcodes sit in command bits 15:12: 0 is output-more, 1 is output-last, 2 is input-more and 3 is input-last. For these opcodes the data address, length, direction and last flag appear on the transfer port. The transfer request stays high until the done pulse arrives.
- R5: A transfer whose data address is zero, or whose key (command bits 10:8) is 4 or more, kills the channel. Any opcode other than 0-3, 6 (no-op) or 7 (stop) also kills it. Killing sets DEAD, clears ACTIVE, gives a one-cycle interrupt pulse and leaves the pointer unchanged.
- R6: Interrupt mode is in command bits 5:4, branch mode in bits 3:2 and wait mode in bits 1:0. The encodings are 0 never, 1 if the condition holds, 2 if it does not hold and 3 always. A condition holds when the device status equals select bits 3:0 in every bit position enabled by select bits 19:16.
- R7: When the wait mode is met after a transfer or no-op completes, nothing is written back and the pointer is not moved. The same descriptor is then fetched and executed again.
- R8: On completion the block writes {status, residual} to pointer+12. For a transfer the residual is the count returned by the device. For a no-op it is the residual field that was fetched. Status bits are: 3:0 device status, 4 BT, 5 ACTIVE, 6 DEAD, 7 WAKE, 8 FLUSH, 9 run, and the remaining bits are zero.
- R9: FLUSH is cleared after the write-back of an output-last or input-last descriptor, and it is kept for the other opcodes.
- R10: After a write-back, the interrupt output pulses for one cycle when the interrupt mode is met.
- R11: A taken branch loads the pointer from the dependent word with its low four bits cleared and sets BT. Otherwise the pointer grows by 16 and BT clears.
- R12: Stop clears ACTIVE, DEAD and FLUSH and leaves the pointer unchanged.
- R13: A pointer load stores the value with its low four bits cleared. The load is ignored while ACTIVE is set.
- R14: A rising run input sets ACTIVE and clears DEAD, and a falling run input clears both. A wake pulse sets WAKE and ACTIVE. A flush pulse sets FLUSH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Channel run level |
| wake_i | input | 1 | Wake pulse |
| flush_i | input | 1 | Flush request pulse |
| ptr_ld_i | input | 1 | Command pointer load strobe |
| ptr_val_i | input | ADDR_W | Command pointer load value |
| intr_sel_i | input | 32 | Interrupt condition select (mask 19:16, value 3:0) |
| brch_sel_i | input | 32 | Branch condition select |
| wait_sel_i | input | 32 | Wait condition select |
| dev_stat_i | input | 4 | Device status bits |
| stat_o | output | 16 | Channel status word |
| ptr_o | output | ADDR_W | Command pointer |
| irq_o | output | 1 | One-cycle interrupt pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| xfer_req_o | output | 1 | Transfer request |
| xfer_out_o | output | 1 | Transfer direction, 1 for output |
| xfer_last_o | output | 1 | Transfer is a last variant |
| xfer_addr_o | output | ADDR_W | Transfer data address |
| xfer_len_o | output | 16 | Transfer request length |
| xfer_done_i | input | 1 | Transfer completion pulse |
| xfer_resid_i | input | 16 | Residual count, valid with done |

## Verification
The bench builds the block with a 16-bit address width. This keeps the memory model small, and every descriptor, branch target and data buffer fits in a compact address space. With that width the bench can run a whole chain: two transfers, a branch, a no-op and a stop, with every write-back word checked. It also reaches each kill cause, a wait loop that repeats until the device status changes, and a pointer load made during a long transfer.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_XFER, S_CHECK, S_WB
    } seq_state_e;

    typedef enum logic [1:0] {
        M_NEVER  = 2'd0,
        M_IFSET  = 2'd1,
        M_IFCLR  = 2'd2,
        M_ALWAYS = 2'd3
    } cond_mode_e;

    localparam logic [3:0] OP_NOP  = 4'd6;
    localparam logic [3:0] OP_STOP = 4'd7;

    typedef struct packed {
        logic       is_xfer;
        logic       is_out;
        logic       is_last;
        logic       is_nop;
        logic       is_stop;
        logic       kill;
        cond_mode_e imode;
        cond_mode_e bmode;
        cond_mode_e wmode;
        logic [15:0] len;
    } desc_dec_t;

endpackage

// File: rtl/dcs_cond.sv
module dcs_cond
    import dcs_pkg::*;
(
    input  logic [3:0]  dev_i,
    input  logic [31:0] sel_i,
    input  cond_mode_e  mode_i,
    output logic        hit_o
);
    logic match;
    logic cond_unused;

    assign match       = (((dev_i ^ sel_i[3:0]) & sel_i[19:16]) == 4'd0);
    assign cond_unused = ^{sel_i[31:20], sel_i[15:4]};

    always_comb begin
        unique case (mode_i)
            M_NEVER:  hit_o = 1'b0;
            M_IFSET:  hit_o = match;
            M_IFCLR:  hit_o = !match;
            default:  hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dcs_decode.sv
module dcs_decode
    import dcs_pkg::*;
(
    input  logic [31:0] w0_i,
    input  logic [31:0] w1_i,
    output desc_dec_t   dec_o
);
    logic [3:0] op;
    logic       dcd_unused;

    assign op         = w0_i[31:28];
    assign dcd_unused = ^{w0_i[27], w0_i[25:24], w0_i[23:22]};

    always_comb begin
        dec_o.is_xfer = (op[3:2] == 2'b00);
        dec_o.is_out  = !op[1];
        dec_o.is_last = op[0];
        dec_o.is_nop  = (op == OP_NOP);
        dec_o.is_stop = (op == OP_STOP);
        dec_o.imode   = cond_mode_e'(w0_i[21:20]);
        dec_o.bmode   = cond_mode_e'(w0_i[19:18]);
        dec_o.wmode   = cond_mode_e'(w0_i[17:16]);
        dec_o.len     = w0_i[15:0];
        if (dec_o.is_xfer)
            dec_o.kill = w0_i[26] || (w1_i == 32'd0);
        else
            dec_o.kill = !(dec_o.is_nop || dec_o.is_stop);
    end
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
    import dcs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wake_i,
    input  logic              flush_i,
    input  logic              ptr_ld_i,
    input  logic [ADDR_W-1:0] ptr_val_i,
    input  logic [31:0]       intr_sel_i,
    input  logic [31:0]       brch_sel_i,
    input  logic [31:0]       wait_sel_i,
    input  logic [3:0]        dev_stat_i,
    output logic [15:0]       stat_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              irq_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              xfer_req_o,
    output logic              xfer_out_o,
    output logic              xfer_last_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [15:0]       xfer_len_o,
    input  logic              xfer_done_i,
    input  logic [15:0]       xfer_resid_i
);
    localparam int          DESC_BYTES = 16;
    localparam int          ALIGN_W    = $clog2(DESC_BYTES);
    localparam int          N_COND     = 3;
    localparam logic [1:0]  LAST_BEAT  = 2'd3;

    typedef struct packed {
        seq_state_e        st;
        logic [1:0]        beat;
        logic [ADDR_W-1:0] ptr;
        logic [31:0]       w0;
        logic [31:0]       w1;
        logic [31:0]       w2;
        logic [15:0]       resid;
        logic              active;
        logic              dead;
        logic              bt;
        logic              wake;
        logic              flush;
        logic              run;
        logic              irq;
    } seq_regs_t;

    seq_regs_t q, d;
    desc_dec_t dec;

    logic [31:0]   sel_v  [N_COND];
    cond_mode_e    mode_v [N_COND];
    logic [N_COND-1:0] hit;
    logic          seq_unused;

    dcs_decode u_decode (.w0_i(q.w0), .w1_i(q.w1), .dec_o(dec));

    assign sel_v[0]  = intr_sel_i;
    assign sel_v[1]  = brch_sel_i;
    assign sel_v[2]  = wait_sel_i;
    assign mode_v[0] = dec.imode;
    assign mode_v[1] = dec.bmode;
    assign mode_v[2] = dec.wmode;

    for (genvar g = 0; g < N_COND; g++) begin : g_cond
        dcs_cond u_cond (
            .dev_i  (dev_stat_i),
            .sel_i  (sel_v[g]),
            .mode_i (mode_v[g]),
            .hit_o  (hit[g])
        );
    end

    assign seq_unused = ^{q.w2, q.w1};

    assign stat_o = {6'd0, run_i, q.flush, q.wake, q.dead, q.active, q.bt, dev_stat_i};
    assign ptr_o  = q.ptr;
    assign irq_o  = q.irq;

    assign mem_req_o   = (q.st == S_FETCH) || (q.st == S_WB);
    assign mem_we_o    = (q.st == S_WB);
    assign mem_addr_o  = (q.st == S_WB) ? q.ptr + ADDR_W'(12)
                                        : q.ptr + ADDR_W'({q.beat, 2'b00});
    assign mem_wdata_o = {stat_o, q.resid};

    assign xfer_req_o  = (q.st == S_XFER);
    assign xfer_out_o  = dec.is_out;
    assign xfer_last_o = dec.is_last;
    assign xfer_addr_o = q.w1[ADDR_W-1:0];
    assign xfer_len_o  = dec.len;

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (run_i && q.active) begin
                    d.st   = S_FETCH;
                    d.beat = 2'd0;
                    d.wake = 1'b0;
                end
            end
            S_FETCH: begin
                if (mem_ack_i) begin
                    unique case (q.beat)
                        2'd0:    d.w0    = mem_rdata_i;
                        2'd1:    d.w1    = mem_rdata_i;
                        2'd2:    d.w2    = mem_rdata_i;
                        default: d.resid = mem_rdata_i[15:0];
                    endcase
                    if (q.beat == LAST_BEAT) d.st = S_DECODE;
                    else                     d.beat = q.beat + 2'd1;
                end
            end
            S_DECODE: begin
                if (dec.is_stop) begin
                    d.active = 1'b0;
                    d.dead   = 1'b0;
                    d.flush  = 1'b0;
                    d.st     = S_IDLE;
                end else if (dec.kill) begin
                    d.dead   = 1'b1;
                    d.active = 1'b0;
                    d.irq    = 1'b1;
                    d.st     = S_IDLE;
                end else if (dec.is_nop) begin
                    d.st = S_CHECK;
                end else begin
                    d.st = S_XFER;
                end
            end
            S_XFER: begin
                if (xfer_done_i) begin
                    d.resid = xfer_resid_i;
                    d.st    = S_CHECK;
                end
            end
            S_CHECK: begin
                d.st = hit[2] ? S_IDLE : S_WB;
            end
            S_WB: begin
                if (mem_ack_i) begin
                    if (dec.is_xfer && dec.is_last) d.flush = 1'b0;
                    d.irq = hit[0];
                    if (hit[1]) begin
                        d.ptr = {q.w2[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                        d.bt  = 1'b1;
                    end else begin
                        d.ptr = q.ptr + ADDR_W'(DESC_BYTES);
                        d.bt  = 1'b0;
                    end
                    d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (run_i && !q.run) begin
            d.active = 1'b1;
            d.dead   = 1'b0;
        end else if (!run_i && q.run) begin
            d.active = 1'b0;
            d.dead   = 1'b0;
        end
        if (wake_i) begin
            d.wake   = 1'b1;
            d.active = 1'b1;
        end
        if (flush_i) d.flush = 1'b1;
        if (ptr_ld_i && !q.active && q.st == S_IDLE)
            d.ptr = {ptr_val_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        d.run = run_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: consecutive fetch beats walk the descriptor four bytes at a time
    a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FETCH && mem_ack_i && q.beat != LAST_BEAT)
            |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

    // R3: starting a fetch drops WAKE
    a_r3_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && run_i && q.active && !wake_i) |=> (!stat_o[7] && mem_req_o));

    // R4: transfer request held until done
    a_r4_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_done_i) |=> xfer_req_o);

    // R5: a kill leaves the channel dead and inactive with an interrupt
    a_r5_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DECODE && dec.kill && !wake_i && (run_i == q.run))
            |=> (stat_o[6] && !stat_o[5] && irq_o));

    // R11: after write-back either the pointer stepped by 16 or BT is set
    a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WB && mem_ack_i)
            |=> ((ptr_o == $past(ptr_o) + ADDR_W'(DESC_BYTES)) || stat_o[4]));

    // R12: stop keeps the pointer and ends activity
    a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DECODE && dec.is_stop && !wake_i && (run_i == q.run))
            |=> ($stable(ptr_o) && !stat_o[5] && !stat_o[6]));

endmodule

// File: tb/dcs_seq_tb_top.sv
`timescale 1ns/1ps
module dcs_seq_tb_top;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 0, wake_i = 0, flush_i = 0, ptr_ld_i = 0;
    logic [AW-1:0] ptr_val_i = '0;
    logic [31:0] intr_sel_i = '0, brch_sel_i = '0, wait_sel_i = '0;
    logic [3:0]  dev_stat_i = '0;
    logic [15:0] stat_o;
    logic [AW-1:0] ptr_o, mem_addr_o, xfer_addr_o;
    logic irq_o, mem_req_o, mem_we_o, mem_ack_i = 0;
    logic [31:0] mem_wdata_o, mem_rdata_i = '0;
    logic xfer_req_o, xfer_out_o, xfer_last_o, xfer_done_i = 0;
    logic [15:0] xfer_len_o, xfer_resid_i = '0;

    always #10 clk = ~clk;

    dcs_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .wake_i(wake_i), .flush_i(flush_i),
        .ptr_ld_i(ptr_ld_i), .ptr_val_i(ptr_val_i), .intr_sel_i(intr_sel_i),
        .brch_sel_i(brch_sel_i), .wait_sel_i(wait_sel_i), .dev_stat_i(dev_stat_i),
        .stat_o(stat_o), .ptr_o(ptr_o), .irq_o(irq_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i), .xfer_req_o(xfer_req_o),
        .xfer_out_o(xfer_out_o), .xfer_last_o(xfer_last_o), .xfer_addr_o(xfer_addr_o),
        .xfer_len_o(xfer_len_o), .xfer_done_i(xfer_done_i), .xfer_resid_i(xfer_resid_i)
    );

    bit [31:0] mem [int];
    logic [33:0] xrec_q [$];
    int n_chk = 0, n_fail = 0, irq_cnt = 0, dev_delay = 3, dcnt = 0;
    bit finished = 0;

    // behavioural memory and device models, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack_i = 0; xfer_done_i = 0; dcnt = 0;
        end else begin
            if (irq_o) irq_cnt++;
            if (mem_ack_i) mem_ack_i = 0;
            else if (mem_req_o) begin
                mem_ack_i = 1;
                if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
                else mem_rdata_i = mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 32'd0;
            end
            if (xfer_done_i) xfer_done_i = 0;
            else if (xfer_req_o) begin
                dcnt++;
                if (dcnt >= dev_delay) begin
                    xfer_done_i  = 1;
                    xfer_resid_i = xfer_len_o - 16'd8;
                    xrec_q.push_back({xfer_out_o, xfer_last_o, xfer_len_o, xfer_addr_o});
                    dcnt = 0;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkcmd(input int op, input int key, input int im,
                                          input int bm, input int wm);
        return {4'(op), 1'b0, 3'(key), 2'b00, 2'(im), 2'(bm), 2'(wm)};
    endfunction

    task automatic put_desc(input int a, input logic [15:0] cmd, input logic [15:0] len,
                            input logic [31:0] da, input logic [31:0] dep, input logic [15:0] res);
        mem[a] = {cmd, len}; mem[a+4] = da; mem[a+8] = dep; mem[a+12] = {16'd0, res};
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic pulse_ld(input logic [AW-1:0] v);
        @(negedge clk); ptr_ld_i = 1; ptr_val_i = v;
        @(negedge clk); ptr_ld_i = 0;
        #2;
    endtask

    task automatic set_run(input logic v);
        @(negedge clk); run_i = v;
        tick(2);
    endtask

    task automatic wait_inactive(input string req);
        int n = 0;
        while (stat_o[5] && n < 2000) begin @(negedge clk); n++; end
        #2;
        if (n >= 2000) chk(req, 34'(stat_o), 34'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int irq0, xn;
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 stat", 34'(stat_o), 34'(0));
        chk("R1 ptr", 34'(ptr_o), 34'(0));
        chk("R1 outs", 34'({irq_o, mem_req_o, xfer_req_o}), 34'(0));

        // chain: out-more, in-last branch, nop, stop
        put_desc(16'h100, mkcmd(0, 0, 3, 0, 0), 16'd64, 32'h2000, 32'h0, 16'h0);
        put_desc(16'h110, mkcmd(3, 0, 0, 3, 0), 16'd32, 32'h3000, 32'h0205, 16'h0);
        put_desc(16'h200, mkcmd(6, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 16'h7777);
        put_desc(16'h210, mkcmd(7, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 16'h0);
        pulse_ld(16'h0105);
        chk("R13 align", 34'(ptr_o), 34'(16'h100));
        @(negedge clk); flush_i = 1; @(negedge clk); flush_i = 0; #2;
        chk("R14 flush", 34'(stat_o[8]), 34'(1));
        tick(4);
        chk("R3 no fetch without run", 34'(mem_req_o), 34'(0));
        set_run(1);
        wait_inactive("R12 chain end");
        chk("R4 xfer count", 34'(xrec_q.size()), 34'(2));
        if (xrec_q.size() == 2) begin
            chk("R4 xfer0", xrec_q[0], {1'b1, 1'b0, 16'd64, 16'h2000});
            chk("R4 xfer1", xrec_q[1], {1'b0, 1'b1, 16'd32, 16'h3000});
        end
        chk("R8 wb0", 34'(mem[16'h10C]), 34'(32'h0320_0038));
        chk("R9 wb1 flush kept before last", 34'(mem[16'h11C]), 34'(32'h0320_0018));
        chk("R9 R11 nop wb after branch", 34'(mem[16'h20C]), 34'(32'h0230_7777));
        chk("R10 irq count", 34'(irq_cnt), 34'(1));
        chk("R12 ptr stop", 34'(ptr_o), 34'(16'h210));
        chk("R11 R12 stat", 34'(stat_o), 34'(16'h0200));
        chk("R2 word0 untouched", 34'(mem[16'h100]), 34'({mkcmd(0, 0, 3, 0, 0), 16'd64}));

        // kills
        xn = xrec_q.size();
        put_desc(16'h300, mkcmd(0, 0, 0, 0, 0), 16'd8, 32'h0, 32'h0, 16'h0);
        put_desc(16'h310, mkcmd(2, 4, 0, 0, 0), 16'd8, 32'h4000, 32'h0, 16'h0);
        put_desc(16'h320, mkcmd(5, 0, 0, 0, 0), 16'd4, 32'h4000, 32'h0, 16'h0);
        for (int k = 0; k < 3; k++) begin
            set_run(0);
            chk("R14 run fall clears dead", 34'(stat_o), 34'(0));
            pulse_ld(AW'(16'h300 + 16 * k));
            irq0 = irq_cnt;
            set_run(1);
            tick(20);
            chk("R5 dead", 34'(stat_o), 34'(16'h0240));
            chk("R5 irq", 34'(irq_cnt - irq0), 34'(1));
            chk("R5 ptr kept", 34'(ptr_o), 34'(16'h300 + 16 * k));
        end
        chk("R5 no transfer", 34'(xrec_q.size()), 34'(xn));

        // pointer load ignored while active
        set_run(0);
        dev_delay = 40;
        put_desc(16'h400, mkcmd(1, 0, 0, 0, 0), 16'd16, 32'h5000, 32'h0, 16'h0);
        put_desc(16'h410, mkcmd(7, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 16'h0);
        pulse_ld(16'h400);
        set_run(1);
        tick(15);
        pulse_ld(16'h900);
        chk("R13 ignored while active", 34'(ptr_o), 34'(16'h400));
        wait_inactive("R4 long transfer");
        chk("R11 step", 34'(ptr_o), 34'(16'h410));
        dev_delay = 3;

        // conditions and wait
        set_run(0);
        dev_stat_i = 4'b1010;
        intr_sel_i = 32'h000F_000A;
        brch_sel_i = 32'h0002_0000;
        wait_sel_i = 32'h0001_0000;
        put_desc(16'h500, mkcmd(6, 0, 1, 2, 0), 16'd0, 32'h0, 32'h0600, 16'h0);
        put_desc(16'h600, mkcmd(6, 0, 2, 0, 1), 16'd0, 32'h0, 32'h0, 16'h1234);
        put_desc(16'h610, mkcmd(7, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 16'h0);
        pulse_ld(16'h505);
        chk("R13 load when idle", 34'(ptr_o), 34'(16'h500));
        irq0 = irq_cnt;
        set_run(1);
        tick(150);
        chk("R6 R10 ifset irq", 34'(irq_cnt - irq0), 34'(1));
        chk("R6 R11 ifclr branch", 34'(ptr_o), 34'(16'h600));
        chk("R8 wb500", 34'(mem[16'h50C]), 34'(32'h022A_0000));
        chk("R7 no wb while waiting", 34'(mem[16'h60C]), 34'(32'h0000_1234));
        chk("R7 still active", 34'(stat_o[5]), 34'(1));
        dev_stat_i = 4'b1011;
        wait_inactive("R7 wait release");
        chk("R6 R10 ifclr irq", 34'(irq_cnt - irq0), 34'(2));
        chk("R7 R8 wb600", 34'(mem[16'h60C]), 34'(32'h023B_1234));
        chk("R11 ptr", 34'(ptr_o), 34'(16'h610));
        chk("R11 bt cleared", 34'(stat_o), 34'(16'h020B));

        // wake
        @(negedge clk); wake_i = 1;
        @(negedge clk); wake_i = 0; #2;
        chk("R14 wake sets", 34'({stat_o[7], stat_o[5]}), 34'(2'b11));
        tick(1);
        chk("R3 wake cleared on fetch", 34'(stat_o[7]), 34'(0));
        wait_inactive("R12 wake stop");
        chk("R12 ptr after wake", 34'(ptr_o), 34'(16'h610));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule